// File: doc/BRIEF.md
# Masked Single-Source Interrupt Register Group

This block keeps the pending state and the mask for one interrupt source behind a small word-wide register port, and it drives one level-sensitive interrupt line. A hardware event pulse marks the source pending. Software acknowledges the event by writing a one to the pending bit. The mask register cannot be written directly. Software clears mask bits through an unmask register and sets them through a mask-set register. Both of those registers are write-only strobes that hold no state.

The number of source bits is a parameter, `SRC_W`, and its default is 1. The offsets on the register port are: pending status at 0x0, mask at 0x4, unmask at 0x8 and mask-set at 0xC. All other offsets read as zero. A write takes effect only when it is aligned to a word and all four byte strobes are asserted. Read data is registered and appears on the clock edge that samples `rd_en`. The interrupt line is registered, so it follows the status and the mask one cycle after they change.

Top module: `irq_stat_mask`

## Requirements
- R1: When reset is released, status reads 0x0, mask reads with all `SRC_W` bits set (0x1 by default) and `irq_o` is low.
- R2: A high `hw_event` bit sets the matching status bit on the next clock edge.
- R3: A full-word write to offset 0x0 clears each status bit whose data bit is 1. Status bits whose data bit is 0 keep their value.
- R4: If an event and a clearing status write arrive in the same cycle, the status bit ends up set.
- R5: A write to the mask offset 0x4 leaves the mask unchanged.
- R6: A full-word write to offset 0x8 clears each mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R7: A full-word write to offset 0xC sets each mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R8: Reads of offsets 0x8 and 0xC return 0x0.
- R9: `irq_o` equals the OR of (status AND NOT mask) as it stood one clock edge earlier.
- R10: A write that has any `wr_strb` bit low, or that has `addr[1:0]` not equal to zero, changes neither status nor mask.
- R11: `rd_data` is loaded on the edge that samples `rd_en`. Status and mask sit in bits [SRC_W-1:0], and the bits above them read as zero. A read of any offset other than 0x0, 0x4, 0x8 or 0xC returns 0x0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| addr | input | ADDR_W | Byte offset |
| wr_data | input | 32 | Write data |
| wr_strb | input | 4 | Byte strobes; all four must be set for a write to act |
| rd_data | output | 32 | Registered read data |
| hw_event | input | SRC_W | Event pulses that set status |
| irq_o | output | 1 | Registered level interrupt |

## Verification
A write updates status or mask on the edge that samples it. `irq_o` reflects that update one edge later. A read result appears on the edge that samples `rd_en`. The bench drives inputs on falling edges. It checks `irq_o` one full cycle after the write edge, and it checks read data at the falling edge after the sampling edge. A scoreboard queue pairs each issued read with its expected value in order.

// File: rtl/irq_stat_mask_pkg.sv
// Shared offsets and read-select encoding for the interrupt register group.
// Assumes byte addressing with 32-bit words.
package irq_stat_mask_pkg;
    localparam int DATA_W      = 32;
    localparam int STRB_W      = DATA_W / 8;
    localparam int OFF_STATUS  = 'h0;
    localparam int OFF_MASK    = 'h4;
    localparam int OFF_UNMASK  = 'h8;
    localparam int OFF_MASKSET = 'hC;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_ZERO   = 2'd2
    } rd_sel_e;
endpackage

// File: rtl/irq_stat_mask_decode.sv
// Address decode: turns a qualified bus write into one per-register strobe
// and picks the read source. Assumes at most one access per cycle.
module irq_stat_mask_decode
    import irq_stat_mask_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [STRB_W-1:0] wr_strb,
    output logic              we_status,
    output logic              we_unmask,
    output logic              we_maskset,
    output rd_sel_e           rd_sel
);
    logic aligned;
    logic wr_ok;

    // Qualify writes: word aligned and every byte lane enabled.
    always_comb begin
        aligned    = (addr[1:0] == 2'b00);
        wr_ok      = wr_en && aligned && (&wr_strb);
        we_status  = wr_ok && (addr == ADDR_W'(OFF_STATUS));
        we_unmask  = wr_ok && (addr == ADDR_W'(OFF_UNMASK));
        we_maskset = wr_ok && (addr == ADDR_W'(OFF_MASKSET));
    end

    // Select read source; stateless and unknown offsets give zero.
    always_comb begin
        if (addr == ADDR_W'(OFF_STATUS))    rd_sel = SEL_STATUS;
        else if (addr == ADDR_W'(OFF_MASK)) rd_sel = SEL_MASK;
        else                                rd_sel = SEL_ZERO;
    end
endmodule

// File: rtl/irq_stat_mask_status.sv
// Pending-status bits: set by hardware events, cleared by writing ones.
// An event in the same cycle as a clear keeps the bit set.
module irq_stat_mask_status #(
    parameter int SRC_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] hw_event,
    input  logic             we,
    input  logic [SRC_W-1:0] wdata,
    output logic [SRC_W-1:0] status
);
    for (genvar g = 0; g < SRC_W; g++) begin : g_bit
        // One pending flag per source; event has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)            status[g] <= 1'b0;
            else if (hw_event[g])  status[g] <= 1'b1;
            else if (we && wdata[g]) status[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_stat_mask_mask.sv
// Mask bits, reachable only through the unmask and mask-set strobes.
// Resets with every source masked.
module irq_stat_mask_mask #(
    parameter int SRC_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_unmask,
    input  logic             we_maskset,
    input  logic [SRC_W-1:0] wdata,
    output logic [SRC_W-1:0] mask
);
    // Apply set-ones or clear-ones updates from the strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n)          mask <= '1;
        else if (we_maskset) mask <= mask | wdata;
        else if (we_unmask)  mask <= mask & ~wdata;
    end
endmodule

// File: rtl/irq_stat_mask.sv
// Top of the single-source interrupt register group. Drives a registered
// level interrupt from status AND NOT mask and serves registered reads.
// Assumes SRC_W <= 32 and ADDR_W >= 4.
module irq_stat_mask
    import irq_stat_mask_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SRC_W  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [STRB_W-1:0] wr_strb,
    output logic [DATA_W-1:0] rd_data,
    input  logic [SRC_W-1:0]  hw_event,
    output logic              irq_o
);
    localparam int PAD_W = DATA_W - SRC_W;

    logic             we_status;
    logic             we_unmask;
    logic             we_maskset;
    rd_sel_e          rd_sel;
    logic [SRC_W-1:0] status_q;
    logic [SRC_W-1:0] mask_q;
    logic [SRC_W-1:0] wsrc;

    assign wsrc = wr_data[SRC_W-1:0];

    if (PAD_W > 0) begin : g_pad
        logic unused_hi;
        assign unused_hi = ^wr_data[DATA_W-1:SRC_W];
    end

    irq_stat_mask_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en      (wr_en),
        .addr       (addr),
        .wr_strb    (wr_strb),
        .we_status  (we_status),
        .we_unmask  (we_unmask),
        .we_maskset (we_maskset),
        .rd_sel     (rd_sel)
    );

    irq_stat_mask_status #(.SRC_W(SRC_W)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw_event (hw_event),
        .we       (we_status),
        .wdata    (wsrc),
        .status   (status_q)
    );

    irq_stat_mask_mask #(.SRC_W(SRC_W)) u_mask (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_unmask  (we_unmask),
        .we_maskset (we_maskset),
        .wdata      (wsrc),
        .mask       (mask_q)
    );

    // Register the interrupt level from unmasked pending bits.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= |(status_q & ~mask_q);
    end

    // Load read data on a read request, zero-extended to the word.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else if (rd_en) begin
            case (rd_sel)
                SEL_STATUS: rd_data <= DATA_W'(status_q);
                SEL_MASK:   rd_data <= DATA_W'(mask_q);
                default:    rd_data <= '0;
            endcase
        end
    end
endmodule

// File: rtl/irq_stat_mask_chk.sv
// Property checker for irq_stat_mask, attached through bind.
module irq_stat_mask_chk #(
    parameter int ADDR_W = 8,
    parameter int SRC_W  = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [3:0]        wr_strb,
    input logic [31:0]       rd_data,
    input logic [SRC_W-1:0]  hw_event,
    input logic [SRC_W-1:0]  status_q,
    input logic [SRC_W-1:0]  mask_q,
    input logic              irq_o
);
    logic past_ok;

    // Marks cycles that have a reset-free previous cycle.
    always_ff @(posedge clk) past_ok <= rst_n;

    p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_event) |=> ((status_q & $past(hw_event)) == $past(hw_event)));

    p_mask_direct_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(4)) |=> $stable(mask_q));

    p_strobe_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr == ADDR_W'(8) || addr == ADDR_W'(12))) |=> (rd_data == 32'h0));

    p_irq_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (irq_o == $past(|(status_q & ~mask_q))));

    p_partial_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(&wr_strb) && !(|hw_event)) |=> ($stable(status_q) && $stable(mask_q)));
endmodule

bind irq_stat_mask irq_stat_mask_chk #(.ADDR_W(ADDR_W), .SRC_W(SRC_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wr_strb  (wr_strb),
    .rd_data  (rd_data),
    .hw_event (hw_event),
    .status_q (status_q),
    .mask_q   (mask_q),
    .irq_o    (irq_o)
);

// File: tb/irq_stat_mask_test.sv
// Scoreboard bench: read tasks queue expected words, a monitor compares.
module irq_stat_mask_test;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wr_data = '0;
    logic [3:0]        wr_strb = '0;
    logic [31:0]       rd_data;
    logic [0:0]        hw_event = 1'b0;
    logic              irq_o;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t exp_q[$];
    int    checks = 0;
    int    failures = 0;
    logic  rd_pend = 1'b0;
    bit    done = 1'b0;

    always #2.5 clk = ~clk;

    irq_stat_mask #(.ADDR_W(ADDR_W), .SRC_W(1)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .wr_strb(wr_strb), .rd_data(rd_data),
        .hw_event(hw_event), .irq_o(irq_o)
    );

    // Track which edge loaded read data.
    always @(posedge clk) rd_pend <= rd_en;

    // Monitor: compare each read result against the queue head.
    always @(negedge clk) begin
        if (rd_pend && exp_q.size() > 0) begin
            item_t it;
            it = exp_q.pop_front();
            checks++;
            if (rd_data !== it.exp) begin
                failures++;
                $display("FAIL %s rd_data actual=%h expected=%h", it.tag, rd_data, it.exp);
            end
        end
    end

    task automatic do_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d; wr_strb = s;
        @(negedge clk);
        wr_en = 1'b0; wr_strb = '0;
    endtask

    task automatic do_read(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse_event();
        @(negedge clk);
        hw_event = 1'b1;
        @(negedge clk);
        hw_event = 1'b0;
    endtask

    // irq is due one edge after status/mask settle; wait one cycle first.
    task automatic check_irq(input logic e, input string tag);
        @(negedge clk);
        checks++;
        if (irq_o !== e) begin
            failures++;
            $display("FAIL %s irq_o actual=%b expected=%b", tag, irq_o, e);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check_irq(1'b0, "R1");
        do_read(8'h0, 32'h0, "R1");
        do_read(8'h4, 32'h1, "R1");
        // R2 event sets status while masked; R9 masked keeps irq low
        pulse_event();
        do_read(8'h0, 32'h1, "R2");
        check_irq(1'b0, "R9");
        // R5 direct mask write ignored
        do_write(8'h4, 32'h0, 4'hF);
        do_read(8'h4, 32'h1, "R5");
        // R6 unmask; R9 irq rises
        do_write(8'h8, 32'h1, 4'hF);
        do_read(8'h4, 32'h0, "R6");
        check_irq(1'b1, "R9");
        // R8 strobe registers read zero
        do_read(8'h8, 32'h0, "R8");
        do_read(8'hC, 32'h0, "R8");
        // R10 partial-strobe and misaligned clears ignored
        do_write(8'h0, 32'h1, 4'h1);
        do_read(8'h0, 32'h1, "R10");
        do_write(8'h1, 32'h1, 4'hF);
        do_read(8'h0, 32'h1, "R10");
        // R3 writing zero keeps, writing one clears
        do_write(8'h0, 32'h0, 4'hF);
        do_read(8'h0, 32'h1, "R3");
        do_write(8'h0, 32'h1, 4'hF);
        do_read(8'h0, 32'h0, "R3");
        check_irq(1'b0, "R9");
        // R4 event beats simultaneous clear
        @(negedge clk);
        hw_event = 1'b1; wr_en = 1'b1; addr = 8'h0; wr_data = 32'h1; wr_strb = 4'hF;
        @(negedge clk);
        hw_event = 1'b0; wr_en = 1'b0; wr_strb = '0;
        do_read(8'h0, 32'h1, "R4");
        check_irq(1'b1, "R4");
        // R7 mask-set; R9 irq falls
        do_write(8'hC, 32'h1, 4'hF);
        do_read(8'h4, 32'h1, "R7");
        check_irq(1'b0, "R9");
        // R6 unmask with zero data leaves mask
        do_write(8'h8, 32'h0, 4'hF);
        do_read(8'h4, 32'h1, "R6");
        // R10 partial-strobe unmask ignored
        do_write(8'h8, 32'h1, 4'h7);
        do_read(8'h4, 32'h1, "R10");
        // R7 mask-set with zero data after unmask leaves mask clear
        do_write(8'h8, 32'h1, 4'hF);
        do_write(8'hC, 32'h0, 4'hF);
        do_read(8'h4, 32'h0, "R7");
        // R11 unmapped offset and upper bits read zero
        do_read(8'h10, 32'h0, "R11");
        do_read(8'h0, 32'h1, "R11");
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R11 pending reads actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule